// File: doc/BRIEF.md
# Level-Sensitive Interrupt Router with Fast-Path Routing

The block collects ten level-sensitive interrupt requests and folds them onto two processor request lines: a normal request line and a fast request line. Each source has an enable bit, a routing bit that picks which of the two lines it drives, and (for two sources) a polarity bit that inverts its active level. Software reaches every control and status word over a plain 32-bit register bus with an address, a write strobe, write data and combinational read data.

Enable bits are never written directly. One address sets the enables selected by ones in the write data, and a second address clears the enables selected by ones. The status word shows sources that are both active and enabled. An all-zero status tells the handler the request was spurious. A pending bit follows its input level, so no acknowledge write exists: software silences a source by masking it. For bring-up, a software-written test word can stand in for the live request pins.

Top module: `intr_router`

## Requirements
- R1: After reset, the enable, routing, polarity, input-select and test words all read 0, and both request outputs are low.
- R2: A write to offset 0x08 sets the enable of every source whose write-data bit is 1, and leaves the other enables as they were.
- R3: A write to offset 0x0C clears the enable of every source whose write-data bit is 1, and leaves the other enables as they were. Writing 0x3FF there disables every source.
- R4: Offset 0x00 reads the active-and-enabled sources in bits 9..0. It reads 0 when no enabled source is active.
- R5: Routing word bit i (offset 0x14) sends source i to the normal line when it is 0 and to the fast line when it is 1. Each output is the OR of the active, enabled sources routed to it.
- R6: Polarity word bit i (offset 0x18) makes source i active low when it is 1. This applies only to sources 6 and 8. The polarity bits of every other source are dropped and read back as 0.
- R7: Bit 0 of the input-select word (offset 0x1C) picks the input: 0 takes the live pins, 1 takes the test word at offset 0x20 (bits 9..0).
- R8: Both request outputs are registered. A change at the pins or in the control words appears on the outputs one clock edge later.
- R9: Sources are level-sensitive. A pending bit stays set while its input is active and clears when the input goes inactive, with no acknowledge write.
- R10: Reads of offsets outside the nine mapped words return 0. Writes to read-only offsets (0x00, 0x04, 0x10) and to unmapped offsets change no state.
- R11: Offset 0x10 reads back the enable word. Offset 0x04 reads the selected raw inputs before the polarity correction.
- R12: With every source active and enabled, the status word reads 0x3FF, so a scan from bit 9 downward first finds source 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 10 | Live interrupt request pins |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench targets mask writes that should touch only some bits. A design that treated the set or clear offsets as plain stores would drop enables that were already set. It also drives polarity writes to sources that may not invert; a design that honoured them would raise a request on an idle low pin. Switching the input select while the live pins and the test word disagree shows a multiplexer that ignores the select. Toggling one source between the two routing lines catches a swapped or duplicated OR tree. Directed writes to the status, raw and unmapped offsets expose a decoder that aliases read-only addresses onto control words. Sampling the outputs once before and once after the active edge shows whether the one-cycle output register is missing or doubled.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam logic [7:0] OFF_STATUS = 8'h00;
  localparam logic [7:0] OFF_RAW    = 8'h04;
  localparam logic [7:0] OFF_ENSET  = 8'h08;
  localparam logic [7:0] OFF_ENCLR  = 8'h0C;
  localparam logic [7:0] OFF_ENRD   = 8'h10;
  localparam logic [7:0] OFF_ROUTE  = 8'h14;
  localparam logic [7:0] OFF_POL    = 8'h18;
  localparam logic [7:0] OFF_INSEL  = 8'h1C;
  localparam logic [7:0] OFF_TEST   = 8'h20;

  typedef enum logic [3:0] {
    SEL_STATUS, SEL_RAW, SEL_ENSET, SEL_ENCLR, SEL_ENRD,
    SEL_ROUTE, SEL_POL, SEL_INSEL, SEL_TEST, SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/intr_regs.sv
module intr_regs
  import intr_pkg::*;
#(
  parameter int          NSRC   = 10,
  parameter int          ADDR_W = 8,
  parameter logic [NSRC-1:0] INV_OK = 10'h140
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSRC-1:0]   wdat,
  output reg_sel_e          sel,
  output logic [NSRC-1:0]   en_q,
  output logic [NSRC-1:0]   route_q,
  output logic [NSRC-1:0]   pol_q,
  output logic              insel_q,
  output logic [NSRC-1:0]   test_q
);
  logic [NSRC-1:0] en_d, route_d, pol_d, test_d;
  logic            insel_d;

  always_comb begin
    unique case (addr)
      ADDR_W'(OFF_STATUS): sel = SEL_STATUS;
      ADDR_W'(OFF_RAW):    sel = SEL_RAW;
      ADDR_W'(OFF_ENSET):  sel = SEL_ENSET;
      ADDR_W'(OFF_ENCLR):  sel = SEL_ENCLR;
      ADDR_W'(OFF_ENRD):   sel = SEL_ENRD;
      ADDR_W'(OFF_ROUTE):  sel = SEL_ROUTE;
      ADDR_W'(OFF_POL):    sel = SEL_POL;
      ADDR_W'(OFF_INSEL):  sel = SEL_INSEL;
      ADDR_W'(OFF_TEST):   sel = SEL_TEST;
      default:             sel = SEL_NONE;
    endcase
  end

  always_comb begin
    en_d    = en_q;
    route_d = route_q;
    pol_d   = pol_q;
    insel_d = insel_q;
    test_d  = test_q;
    if (wr) begin
      case (sel)
        SEL_ENSET: en_d    = en_q | wdat;
        SEL_ENCLR: en_d    = en_q & ~wdat;
        SEL_ROUTE: route_d = wdat;
        SEL_POL:   pol_d   = wdat & INV_OK;
        SEL_INSEL: insel_d = wdat[0];
        SEL_TEST:  test_d  = wdat;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
      pol_q   <= '0;
      insel_q <= 1'b0;
      test_q  <= '0;
    end else if (wr) begin
      en_q    <= en_d;
      route_q <= route_d;
      pol_q   <= pol_d;
      insel_q <= insel_d;
      test_q  <= test_d;
    end
  end

  // R2
  enset_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_ENSET) |=> ((en_q & $past(wdat)) == $past(wdat)));

  // R3
  enclr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_ENCLR) |=> ((en_q & $past(wdat)) == '0));

  // R6
  pol_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pol_q & ~INV_OK) == '0));

  // R10
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (sel == SEL_STATUS || sel == SEL_RAW || sel == SEL_ENRD || sel == SEL_NONE))
    |=> ($stable(en_q) && $stable(route_q) && $stable(pol_q) &&
         $stable(insel_q) && $stable(test_q)));
endmodule

// File: rtl/intr_src.sv
module intr_src #(
  parameter int NSRC = 10
) (
  input  logic [NSRC-1:0] pins,
  input  logic [NSRC-1:0] test,
  input  logic            insel,
  input  logic [NSRC-1:0] pol,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] active
);
  always_comb begin
    raw    = insel ? test : pins;
    active = raw ^ pol;
  end
endmodule

// File: rtl/intr_route.sv
module intr_route #(
  parameter int NSRC = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] route,
  output logic            irq_q,
  output logic            fiq_q
);
  logic irq_d, fiq_d;

  always_comb begin
    irq_d = |(pend & ~route);
    fiq_d = |(pend & route);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      fiq_q <= fiq_d;
    end
  end
endmodule

// File: rtl/intr_router.sv
module intr_router
  import intr_pkg::*;
#(
  parameter int NSRC   = 10,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [NSRC-1:0] INV_OK = 10'h140
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int PAD = DATA_W - NSRC;

  reg_sel_e        sel;
  logic [NSRC-1:0] en_q, route_q, pol_q, test_q, raw, active, pend;
  logic            insel_q;
  logic            unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:NSRC];

  intr_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W), .INV_OK(INV_OK)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdat(bus_wdata[NSRC-1:0]), .sel(sel), .en_q(en_q), .route_q(route_q),
    .pol_q(pol_q), .insel_q(insel_q), .test_q(test_q)
  );

  intr_src #(.NSRC(NSRC)) u_src (
    .pins(src_i), .test(test_q), .insel(insel_q), .pol(pol_q),
    .raw(raw), .active(active)
  );

  assign pend = active & en_q;

  intr_route #(.NSRC(NSRC)) u_route (
    .clk(clk), .rst_n(rst_n), .pend(pend), .route(route_q),
    .irq_q(irq_o), .fiq_q(fiq_o)
  );

  always_comb begin
    case (sel)
      SEL_STATUS: bus_rdata = {{PAD{1'b0}}, pend};
      SEL_RAW:    bus_rdata = {{PAD{1'b0}}, raw};
      SEL_ENRD:   bus_rdata = {{PAD{1'b0}}, en_q};
      SEL_ROUTE:  bus_rdata = {{PAD{1'b0}}, route_q};
      SEL_POL:    bus_rdata = {{PAD{1'b0}}, pol_q};
      SEL_INSEL:  bus_rdata = {{(DATA_W-1){1'b0}}, insel_q};
      SEL_TEST:   bus_rdata = {{PAD{1'b0}}, test_q};
      default:    bus_rdata = '0;
    endcase
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> (!irq_o && !fiq_o));

  // R5
  fast_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & route_q) == '0) |=> !fiq_o);

  // R5
  norm_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~route_q) == '0) |=> !irq_o);

  // R9
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((active & en_q) != '0) |-> (bus_addr != ADDR_W'(OFF_STATUS) || bus_rdata != '0));
endmodule

// File: tb/intr_router_tb.sv
module intr_router_tb;
  localparam int N = 10;
  localparam logic [N-1:0] INVM = 10'h140;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src_i = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;

  int compared = 0;
  int mismatched = 0;

  logic [N-1:0] m_en = '0, m_route = '0, m_pol = '0, m_test = '0;
  logic         m_insel = 1'b0;

  always #2.5 clk = ~clk;

  intr_router u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  function automatic logic [N-1:0] m_raw();
    return m_insel ? m_test : src_i;
  endfunction
  function automatic logic [N-1:0] m_pend();
    return (m_raw() ^ m_pol) & m_en;
  endfunction
  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return {22'd0, m_pend()};
      8'h04: return {22'd0, m_raw()};
      8'h10: return {22'd0, m_en};
      8'h14: return {22'd0, m_route};
      8'h18: return {22'd0, m_pol};
      8'h1C: return {31'd0, m_insel};
      8'h20: return {22'd0, m_test};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      8'h08: m_en = m_en | d[N-1:0];
      8'h0C: m_en = m_en & ~d[N-1:0];
      8'h14: m_route = d[N-1:0];
      8'h18: m_pol = d[N-1:0] & INVM;
      8'h1C: m_insel = d[0];
      8'h20: m_test = d[N-1:0];
      default: ;
    endcase
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, m_read(a));
  endtask

  task automatic out_chk(input string req);
    @(negedge clk);
    chk(req, {30'd0, fiq_o, irq_o},
        {30'd0, |(m_pend() & m_route), |(m_pend() & ~m_route)});
    rd_chk(req, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] offs [11];
    offs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h3C};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int a = 0; a <= 8'h20; a += 4) rd_chk("R1", 8'(a));
    chk("R1", {30'd0, fiq_o, irq_o}, 32'd0);

    // R2 / R11: set keeps earlier enables
    wr(8'h08, 32'h005); wr(8'h08, 32'h100);
    rd_chk("R2", 8'h10); chk("R2", bus_rdata, 32'h105);
    // R3: clear only selected bits
    wr(8'h0C, 32'h004);
    rd_chk("R3", 8'h10); chk("R3", bus_rdata, 32'h101);

    // R8: output one edge after input change
    @(negedge clk); src_i = 10'h001; #1;
    chk("R8", {31'd0, irq_o}, 32'd0);
    @(negedge clk);
    chk("R8", {31'd0, irq_o}, 32'd1);
    // R4 / R9: status follows level, clears without ack
    rd_chk("R4", 8'h00); chk("R4", bus_rdata, 32'h001);
    @(negedge clk); src_i = '0;
    out_chk("R9"); chk("R9", bus_rdata, 32'h0);

    // R5: move source 0 to fast line
    wr(8'h14, 32'h001); src_i = 10'h001;
    out_chk("R5"); chk("R5", {30'd0, fiq_o, irq_o}, 32'd2);

    // R6: disallowed polarity ignored, allowed polarity inverts
    src_i = '0;
    wr(8'h08, 32'h3FF); wr(8'h18, 32'h3FF);
    rd_chk("R6", 8'h18); chk("R6", bus_rdata, 32'h140);
    out_chk("R6"); chk("R6", bus_rdata, 32'h140);

    // R7: test word replaces pins
    wr(8'h18, 32'h0); wr(8'h20, 32'h2A0); wr(8'h1C, 32'h1);
    src_i = 10'h015;
    out_chk("R7"); chk("R7", bus_rdata, 32'h2A0);
    rd_chk("R11", 8'h04);
    wr(8'h1C, 32'h0);

    // R10: read-only / unmapped writes ignored
    wr(8'h00, 32'h3FF); wr(8'h04, 32'h3FF); wr(8'h10, 32'h0); wr(8'h24, 32'h3FF);
    rd_chk("R10", 8'h10); chk("R10", bus_rdata, 32'h3FF);
    rd_chk("R10", 8'h24); rd_chk("R10", 8'h02);

    // R12: all pending, scan from bit 9 down
    wr(8'h14, 32'h0); src_i = 10'h3FF;
    out_chk("R12");
    begin
      int hi = -1;
      for (int b = 9; b >= 0; b--) if (hi < 0 && bus_rdata[b]) hi = b;
      chk("R12", 32'(hi), 32'd9);
    end
    // R3: disable all, outputs drop
    wr(8'h0C, 32'h3FF);
    out_chk("R3"); chk("R3", {30'd0, fiq_o, irq_o}, 32'd0);

    // R2 R3 R5: random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom % 3;
      if (op == 0) wr(offs[$urandom % 11], $urandom);
      else if (op == 1) begin @(negedge clk); src_i = N'($urandom); end
      else begin @(negedge clk); rd_chk("R11", offs[$urandom % 11]); end
      out_chk("R5");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule